// File: doc/BRIEF.md
# Drive Fault and Warning Status Registers

This block keeps the latched fault and warning flags of a motor drive controller. It also gates the run command. Detection logic elsewhere raises one-cycle event strobes. Each strobe sets its own bit in a 16-bit fault register or a 16-bit warning register, and the bit stays set until it is cleared on purpose.

A set fault bit stops the drive and blocks any restart. A warning bit is only recorded: the drive keeps running. A status word gives a summary of both registers and shows whether the drive runs. A single indicator output shows the I/O-fault warning.

Software reaches the block through a small register port with one read/write control word and three read-only words. Three control bits act here: a run command, a fault-clear bit and a warning-clear bit. Both clear bits act only when they are released, so software must raise the bit and then drop it. To restart after a fault, software must withdraw the run command, pulse the fault-clear bit, and then raise the run command again.

Top module: `drive_status_regs`

## Requirements
- R1: A strobe on `fault_evt[i]` sets fault bit i one clock later. The bit stays set after the strobe ends and reads back at address 2.
- R2: A strobe on `warn_evt[i]` sets warning bit i, which reads back at address 3. A running drive keeps `drive_run` high.
- R3: The status word at address 1 has these bits: bit 0 = any fault bit set, bit 1 = `drive_run`, bit 9 = any warning bit set. All other bits read 0.
- R4: Control bit 8 clears the whole fault register, but only on its high-to-low transition. While the bit is held high, the register keeps its contents.
- R5: Control bit 9 clears the whole warning register, but only on its high-to-low transition. While the bit is held high, the register keeps its contents.
- R6: An event strobe that is active in the same cycle as a clear leaves its bit set. All other bits are cleared.
- R7: `drive_run` rises only after a low-to-high transition of control bit 0 while the fault register is empty. It falls one clock after any fault bit is set, or one clock after bit 0 goes low.
- R8: A run command that stays high through a fault clear does not restart the drive. Bit 0 must go low and then high again.
- R9: `io_led` follows warning bit 0 (the I/O-fault warning), one clock later. Other warning bits leave it low.
- R10: The control word at address 0 reads back what was written to it. Writes to addresses 1 to 3 are ignored.
- R11: After reset, all registers, `drive_run`, `io_led` and `bus_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_evt | input | 16 | Fault event strobes, one per fault bit |
| warn_evt | input | 16 | Warning event strobes, one per warning bit |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 faults, 3 warnings |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data, valid one clock after the address |
| drive_run | output | 1 | Drive enable |
| io_led | output | 1 | I/O-fault warning indicator |

## Verification
The bench holds each clear bit high for several cycles and checks that the register is still full. A design that clears on the level or on the rising edge fails this check. It pulses an event in the same cycles as a warning clear, so a design that lets the clear win loses that bit. It clears a fault while the run command stays high, which exposes a design that restarts from the command level. It also records warnings during a run, which catches a design that lets a warning stop the drive.

// File: rtl/drive_status_pkg.sv
package drive_status_pkg;
  localparam int CTRL_CMD_BIT  = 0;
  localparam int CTRL_FCLR_BIT = 8;
  localparam int CTRL_WCLR_BIT = 9;
  localparam int STAT_FLT_BIT  = 0;
  localparam int STAT_RUN_BIT  = 1;
  localparam int STAT_WRN_BIT  = 9;

  typedef enum logic [1:0] {
    ADR_CTRL  = 2'd0,
    ADR_STAT  = 2'd1,
    ADR_FAULT = 2'd2,
    ADR_WARN  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/sticky_status.sv
module sticky_status #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_lvl_i,
  output logic [W-1:0] bits_o
);
  logic clr_prev;
  logic clr_fall;

  assign clr_fall = clr_prev & ~clr_lvl_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_prev <= 1'b0;
      bits_o   <= '0;
    end else begin
      clr_prev <= clr_lvl_i;
      bits_o   <= (clr_fall ? '0 : bits_o) | set_i;
    end
  end

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((bits_o & $past(set_i)) == $past(set_i))); // R1
  AST_HOLD_UNLESS_FALL: assert property (@(posedge clk) disable iff (rst)
    !clr_fall |=> ((~bits_o & $past(bits_o)) == '0)); // R4
  AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
    clr_fall |=> (bits_o == $past(set_i))); // R6
endmodule

// File: rtl/run_gate.sv
module run_gate (
  input  logic clk,
  input  logic rst,
  input  logic cmd_i,
  input  logic fault_any_i,
  output logic run_o
);
  logic cmd_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_prev <= 1'b0;
      run_o    <= 1'b0;
    end else begin
      cmd_prev <= cmd_i;
      if (fault_any_i || !cmd_i)
        run_o <= 1'b0;
      else if (!cmd_prev)
        run_o <= 1'b1;
    end
  end

  AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (rst)
    fault_any_i |=> !run_o); // R7
  AST_START_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(run_o) |-> ($past(cmd_i) && !$past(cmd_i, 2))); // R8
  AST_WARN_NO_STOP: assert property (@(posedge clk) disable iff (rst)
    (run_o && cmd_i && !fault_any_i) |=> run_o); // R2
endmodule

// File: rtl/drive_status_regs.sv
module drive_status_regs
  import drive_status_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_FLT   = 16,
  parameter int NUM_WRN   = 16,
  parameter int IOFLT_BIT = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_FLT-1:0] fault_evt,
  input  logic [NUM_WRN-1:0] warn_evt,
  input  logic [1:0]         bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               drive_run,
  output logic               io_led
);
  logic [DATA_W-1:0]  ctrl_q;
  logic [NUM_FLT-1:0] flt_bits;
  logic [NUM_WRN-1:0] wrn_bits;
  logic [DATA_W-1:0]  stat_word;
  logic [DATA_W-1:0]  rd_mux;
  reg_addr_e          addr;

  assign addr = reg_addr_e'(bus_addr);

  always_ff @(posedge clk) begin
    if (rst)
      ctrl_q <= '0;
    else if (bus_wr && addr == ADR_CTRL)
      ctrl_q <= bus_wdata;
  end

  sticky_status #(.W(NUM_FLT)) u_fault (
    .clk(clk), .rst(rst), .set_i(fault_evt),
    .clr_lvl_i(ctrl_q[CTRL_FCLR_BIT]), .bits_o(flt_bits));

  sticky_status #(.W(NUM_WRN)) u_warn (
    .clk(clk), .rst(rst), .set_i(warn_evt),
    .clr_lvl_i(ctrl_q[CTRL_WCLR_BIT]), .bits_o(wrn_bits));

  run_gate u_run (
    .clk(clk), .rst(rst), .cmd_i(ctrl_q[CTRL_CMD_BIT]),
    .fault_any_i(|flt_bits), .run_o(drive_run));

  always_comb begin
    stat_word               = '0;
    stat_word[STAT_FLT_BIT] = |flt_bits;
    stat_word[STAT_RUN_BIT] = drive_run;
    stat_word[STAT_WRN_BIT] = |wrn_bits;
  end

  always_comb begin
    unique case (addr)
      ADR_CTRL:  rd_mux = ctrl_q;
      ADR_STAT:  rd_mux = stat_word;
      ADR_FAULT: rd_mux = DATA_W'(flt_bits);
      default:   rd_mux = DATA_W'(wrn_bits);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      io_led    <= 1'b0;
    end else begin
      bus_rdata <= rd_mux;
      io_led    <= wrn_bits[IOFLT_BIT];
    end
  end

  AST_RO_WRITES_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && addr != ADR_CTRL) |=> $stable(ctrl_q)); // R10
  AST_LED_IOFLT_ONLY: assert property (@(posedge clk) disable iff (rst)
    io_led |-> $past(wrn_bits[IOFLT_BIT])); // R9
endmodule

// File: tb/tb_drive_status_regs.sv
module tb_drive_status_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] fault_evt = '0;
  logic [15:0] warn_evt = '0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        drive_run;
  logic        io_led;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  drive_status_regs dut (
    .clk(clk), .rst(rst), .fault_evt(fault_evt), .warn_evt(warn_evt),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .drive_run(drive_run), .io_led(io_led));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic pulse_fault(input logic [15:0] m);
    @(negedge clk); fault_evt = m;
    @(negedge clk); fault_evt = '0;
  endtask

  task automatic pulse_warn(input logic [15:0] m);
    @(negedge clk); warn_evt = m;
    @(negedge clk); warn_evt = '0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk("R11 reg after reset", v, 16'h0000);
    end
    chk("R11 drive_run after reset", {15'b0, drive_run}, 16'h0000);
    chk("R11 io_led after reset", {15'b0, io_led}, 16'h0000);
  endtask

  task automatic t_run_and_warn;
    logic [15:0] v;
    wr(2'd0, 16'h0001); idle(2);
    chk("R7 start on command edge", {15'b0, drive_run}, 16'h0001);
    pulse_warn(16'h0010);
    rd(2'd3, v);
    chk("R2 warning bit latched", v, 16'h0010);
    chk("R2 drive still runs", {15'b0, drive_run}, 16'h0001);
    chk("R9 no led for other warning", {15'b0, io_led}, 16'h0000);
    rd(2'd1, v);
    chk("R3 status run+warn", v, 16'h0202);
    pulse_warn(16'h0001);
    idle(2);
    chk("R9 led for io warning", {15'b0, io_led}, 16'h0001);
  endtask

  task automatic t_warn_clear;
    logic [15:0] v;
    wr(2'd0, 16'h0201); idle(4);
    rd(2'd3, v);
    chk("R5 held clear keeps warnings", v, 16'h0011);
    wr(2'd0, 16'h0001); idle(2);
    rd(2'd3, v);
    chk("R5 release clears warnings", v, 16'h0000);
    chk("R9 led off after clear", {15'b0, io_led}, 16'h0000);
    rd(2'd1, v);
    chk("R3 status run only", v, 16'h0002);
  endtask

  task automatic t_fault_and_restart;
    logic [15:0] v;
    pulse_fault(16'h0020);
    idle(1);
    chk("R7 fault stops drive", {15'b0, drive_run}, 16'h0000);
    rd(2'd2, v);
    chk("R1 fault bit sticky", v, 16'h0020);
    rd(2'd1, v);
    chk("R3 status fault", v, 16'h0001);
    wr(2'd0, 16'h0101); idle(4);
    rd(2'd2, v);
    chk("R4 held clear keeps faults", v, 16'h0020);
    wr(2'd0, 16'h0001); idle(2);
    rd(2'd2, v);
    chk("R4 release clears faults", v, 16'h0000);
    idle(2);
    chk("R8 no restart from held command", {15'b0, drive_run}, 16'h0000);
    wr(2'd0, 16'h0000); idle(1);
    wr(2'd0, 16'h0001); idle(2);
    chk("R7 restart after new edge", {15'b0, drive_run}, 16'h0001);
  endtask

  task automatic t_event_vs_clear;
    logic [15:0] v;
    pulse_warn(16'h0004);
    wr(2'd0, 16'h0201); idle(1);
    @(negedge clk);
    bus_addr = 2'd0; bus_wdata = 16'h0001; bus_wr = 1'b1; warn_evt = 16'h0080;
    @(negedge clk);
    bus_wr = 1'b0;
    @(negedge clk);
    warn_evt = '0;
    rd(2'd3, v);
    chk("R6 event survives clear", v, 16'h0080);
  endtask

  task automatic t_readonly;
    logic [15:0] v;
    wr(2'd1, 16'hFFFF);
    wr(2'd2, 16'hFFFF);
    wr(2'd3, 16'hFFFF);
    idle(1);
    rd(2'd2, v);
    chk("R10 fault reg not writable", v, 16'h0000);
    rd(2'd3, v);
    chk("R10 warn reg not writable", v, 16'h0080);
    rd(2'd0, v);
    chk("R10 control readback", v, 16'h0001);
    chk("R10 drive unaffected", {15'b0, drive_run}, 16'h0001);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_run_and_warn();
    t_warn_clear();
    t_fault_and_restart();
    t_event_vs_clear();
    t_readonly();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule